// File: doc/BRIEF.md
# Byte-Wide Host Mailbox Port

This block is a slave register port. It lets a host with an 8-bit bus exchange 32-bit words with logic inside the chip. The host reaches sixteen byte locations through a 4-bit address. Two independent conduits, one for messages and one for data, each carry a 32-bit word as four byte registers. The most significant byte sits at the lowest address. The host stages the upper three bytes of an inbound word. Writing the least significant byte hands the whole word to the core side in one clock cycle. In the other direction, the core loads an outbound word into the port. The host reads that word byte by byte, and its read of the least significant byte retires the word.

A control byte holds an interrupt event mask and an acknowledge command. A status byte reports the state of both conduits and of the interrupt. An active-low interrupt output goes low on any enabled event and stays low until the host acknowledges it. A separate request output tells the host that an outbound word is waiting.

Top module: `host_mailbox_port`

## Requirements
- R1: After reset, status and control read 0x00, `host_irq_n` is 1, `host_req` is 0 and neither inbound valid strobe is high.
- R2: Byte order is most significant first. Addresses 0..3 map bits 31:24, 23:16, 15:8 and 7:0 of the message word, and addresses 4..7 map the same bits of the data word. A host read (`host_cs`=1, `host_rd`=1) of those addresses returns the byte of that conduit's outbound word at that position. When no read is selected, `host_rdata` is 0x00.
- R3: A host write to address 3 (or 7) raises that conduit's inbound valid strobe for exactly one cycle, in the cycle after the write. The strobe carries the word built from the three earlier staged bytes and the new byte.
- R4: Host writes to the upper three byte addresses of a conduit only stage bytes and raise no valid strobe.
- R5: A core load pulse sets the conduit's outbound-available flag and captures the word. A host read of the conduit's last byte clears the flag after that edge. If a load and that read fall on the same edge, the load wins and the flag stays set.
- R6: The two conduits are independent: an access to one never changes the other conduit's strobe, word or flags.
- R7: The status byte at address 9 has bit 0 = message inbound pending, bit 1 = message outbound available, bit 2 = data inbound pending, bit 3 = data outbound available, bit 4 = interrupt active, and bits 7:5 = 0. Each bit reflects the access that changed it from the next cycle on.
- R8: The control byte at address 8 stores the event mask in bits 3:0 and reads it back with bits 7:4 as 0. Bit 7 of a control write is the acknowledge command and is not stored.
- R9: Mask bits are 0 = message outbound loaded, 1 = message inbound consumed, 2 = data outbound loaded, 3 = data inbound consumed. An event whose mask bit is set drives `host_irq_n` low from the next cycle. The output stays low until a control write with bit 7 set. If an enabled event coincides with the acknowledge, the output stays low.
- R10: `host_req` is 1 exactly while at least one outbound-available flag is set.
- R11: Addresses 10..15 read 0x00, and writes to them change no register, flag or output.
- R12: An inbound pending flag is set by the last-byte write and cleared by that conduit's core acknowledge pulse. An acknowledge while nothing is pending is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs | input | 1 | Host chip select |
| host_wr | input | 1 | Host write strobe (one cycle per access) |
| host_rd | input | 1 | Host read strobe (one cycle per access) |
| host_addr | input | 4 | Byte register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 0 when no read is selected |
| host_irq_n | output | 1 | Interrupt to host, active low |
| host_req | output | 1 | Outbound word waiting |
| msg_in_valid | output | 1 | One-cycle strobe: inbound message word |
| msg_in_word | output | 32 | Inbound message word |
| msg_in_ack | input | 1 | Core has consumed the inbound message |
| msg_out_load | input | 1 | Core loads an outbound message word |
| msg_out_word | input | 32 | Outbound message word |
| data_in_valid | output | 1 | One-cycle strobe: inbound data word |
| data_in_word | output | 32 | Inbound data word |
| data_in_ack | input | 1 | Core has consumed the inbound data word |
| data_out_load | input | 1 | Core loads an outbound data word |
| data_out_word | input | 32 | Outbound data word |

## Verification
The assertions assume that the host never raises read and write together, and that each strobe lasts one cycle per access. The strobe and flag properties also assume that core acknowledge and load are single-cycle pulses. The bench drives every host access through one task that holds a strobe for exactly one clock, and it pulses core inputs the same way. Only the deliberate collisions step outside this pattern: a load together with a last-byte read, and an event together with an acknowledge. A behavioural model with the same inputs predicts every output, and the bench compares the two on every clock.

// File: rtl/hmp_pkg.sv
// Shared constants for the host mailbox port.
// Assumes a byte-wide host bus; the address layout is derived from the word width.
package hmp_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned EVT_N    = 4;
    localparam int unsigned ACK_BIT  = 7;
    // status bit positions
    localparam int unsigned ST_MPEND = 0;
    localparam int unsigned ST_MAVL  = 1;
    localparam int unsigned ST_DPEND = 2;
    localparam int unsigned ST_DAVL  = 3;
    localparam int unsigned ST_IRQ   = 4;
endpackage

// File: rtl/hmp_conduit.sv
// One bidirectional conduit: stages inbound bytes MS first and commits on the
// last-lane write; holds one outbound word retired by a read of the last lane.
// Assumes lane_wr is one-hot or zero and that core_load/core_ack are pulses.
module hmp_conduit #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W/BYTE_W-1:0]  lane_wr,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic                      rd_last,
    input  logic                      core_load,
    input  logic [WORD_W-1:0]         core_word,
    input  logic                      core_ack,
    output logic                      to_valid,
    output logic [WORD_W-1:0]         to_word,
    output logic                      pend,
    output logic                      avail,
    output logic [WORD_W-1:0]         out_word,
    output logic                      evt_load,
    output logic                      evt_done
);
    localparam int unsigned LANES   = WORD_W / BYTE_W;
    localparam int unsigned STAGE_W = WORD_W - BYTE_W;

    logic [BYTE_W-1:0]  stage [LANES-1];
    logic [STAGE_W-1:0] stage_flat;
    logic               wr_last;

    assign wr_last  = lane_wr[LANES-1];
    assign evt_load = core_load;
    assign evt_done = core_ack & pend;

    // Capture staged bytes of the upper lanes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES - 1; i++) begin
            if (!rst_n)          stage[i] <= '0;
            else if (lane_wr[i]) stage[i] <= wdata;
        end
    end

    // Place staged bytes most significant first.
    always_comb begin
        stage_flat = '0;
        for (int i = 0; i < LANES - 1; i++)
            stage_flat[STAGE_W-1-i*BYTE_W -: BYTE_W] = stage[i];
    end

    // Commit the inbound word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_valid <= 1'b0;
            to_word  <= '0;
        end else begin
            to_valid <= wr_last;
            if (wr_last) to_word <= {stage_flat, wdata};
        end
    end

    // Track the inbound pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (wr_last)  pend <= 1'b1;
        else if (core_ack) pend <= 1'b0;
    end

    // Hold the outbound word and its available flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail    <= 1'b0;
            out_word <= '0;
        end else if (core_load) begin
            avail    <= 1'b1;
            out_word <= core_word;
        end else if (rd_last) begin
            avail    <= 1'b0;
        end
    end

    // R3
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_valid |-> $past(wr_last));
    // R4
    stage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wr[LANES-2:0]) |=> !to_valid);
    // R5
    avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> avail);
    // R5
    avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail) |-> $past(rd_last));
    // R12
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !core_ack) |=> pend);
endmodule

// File: rtl/hmp_irq.sv
// Control register and interrupt latch: stores the event mask, latches any
// enabled event and releases only on an acknowledge command.
// Assumes ctrl_wr is a single-cycle host write strobe to the control address.
module hmp_irq #(
    parameter int unsigned EVT_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [EVT_N-1:0] mask_in,
    input  logic             ack_cmd,
    input  logic [EVT_N-1:0] evt,
    output logic [EVT_N-1:0] mask,
    output logic             irq_active
);
    logic hit;
    logic ack;

    assign hit = |(evt & mask);
    assign ack = ctrl_wr & ack_cmd;

    // Store the event mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (ctrl_wr) mask <= mask_in;
    end

    // Latch enabled events; a fresh event beats the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_active <= 1'b0;
        else if (hit) irq_active <= 1'b1;
        else if (ack) irq_active <= 1'b0;
    end

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active && !ack) |=> irq_active);
    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_active) |-> $past(|(evt & mask)));
endmodule

// File: rtl/host_mailbox_port.sv
// Top: decodes the 4-bit host address into two conduits, control and status,
// muxes read data and drives the host interrupt and request outputs.
// Assumes host_rd and host_wr are never high together.
module host_mailbox_port #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_cs,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [hmp_pkg::BYTE_W-1:0]  host_wdata,
    output logic [hmp_pkg::BYTE_W-1:0]  host_rdata,
    output logic                        host_irq_n,
    output logic                        host_req,
    output logic                        msg_in_valid,
    output logic [WORD_W-1:0]           msg_in_word,
    input  logic                        msg_in_ack,
    input  logic                        msg_out_load,
    input  logic [WORD_W-1:0]           msg_out_word,
    output logic                        data_in_valid,
    output logic [WORD_W-1:0]           data_in_word,
    input  logic                        data_in_ack,
    input  logic                        data_out_load,
    input  logic [WORD_W-1:0]           data_out_word
);
    import hmp_pkg::*;
    localparam int unsigned LANES     = WORD_W / BYTE_W;
    localparam int unsigned CTRL_ADDR = 2 * LANES;
    localparam int unsigned STAT_ADDR = 2 * LANES + 1;

    logic [LANES-1:0]  lane_wr [2];
    logic              rd_last [2];
    logic              pend    [2];
    logic              avail   [2];
    logic              ev_load [2];
    logic              ev_done [2];
    logic [WORD_W-1:0] ob_word [2];
    logic [WORD_W-1:0] core_w  [2];
    logic              core_ld [2];
    logic              core_ak [2];
    logic              to_v    [2];
    logic [WORD_W-1:0] to_w    [2];
    logic [EVT_N-1:0]  mask;
    logic              irq_active;
    logic              wr_sel;
    logic              rd_sel;
    logic [BYTE_W-1:0] rd_mux;

    assign wr_sel = host_cs & host_wr;
    assign rd_sel = host_cs & host_rd;

    assign core_w[0]  = msg_out_word;
    assign core_w[1]  = data_out_word;
    assign core_ld[0] = msg_out_load;
    assign core_ld[1] = data_out_load;
    assign core_ak[0] = msg_in_ack;
    assign core_ak[1] = data_in_ack;

    // One conduit per direction pair: message (0) and data (1).
    for (genvar c = 0; c < 2; c++) begin : g_cond
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_wr[c][i] = wr_sel && (host_addr == ADDR_W'(c*LANES + i));
        end
        assign rd_last[c] = rd_sel && (host_addr == ADDR_W'(c*LANES + LANES - 1));

        hmp_conduit #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .lane_wr   (lane_wr[c]),
            .wdata     (host_wdata),
            .rd_last   (rd_last[c]),
            .core_load (core_ld[c]),
            .core_word (core_w[c]),
            .core_ack  (core_ak[c]),
            .to_valid  (to_v[c]),
            .to_word   (to_w[c]),
            .pend      (pend[c]),
            .avail     (avail[c]),
            .out_word  (ob_word[c]),
            .evt_load  (ev_load[c]),
            .evt_done  (ev_done[c])
        );
    end

    hmp_irq #(.EVT_N(EVT_N)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_sel && (host_addr == ADDR_W'(CTRL_ADDR))),
        .mask_in    (host_wdata[EVT_N-1:0]),
        .ack_cmd    (host_wdata[ACK_BIT]),
        .evt        ({ev_done[1], ev_load[1], ev_done[0], ev_load[0]}),
        .mask       (mask),
        .irq_active (irq_active)
    );

    assign msg_in_valid  = to_v[0];
    assign msg_in_word   = to_w[0];
    assign data_in_valid = to_v[1];
    assign data_in_word  = to_w[1];
    assign host_irq_n    = ~irq_active;
    assign host_req      = avail[0] | avail[1];

    // Select the addressed byte; unimplemented addresses give zero.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < LANES; i++)
                if (host_addr == ADDR_W'(c*LANES + i))
                    rd_mux = ob_word[c][WORD_W-1-i*BYTE_W -: BYTE_W];
        if (host_addr == ADDR_W'(CTRL_ADDR))
            rd_mux = BYTE_W'(mask);
        if (host_addr == ADDR_W'(STAT_ADDR)) begin
            rd_mux           = '0;
            rd_mux[ST_MPEND] = pend[0];
            rd_mux[ST_MAVL]  = avail[0];
            rd_mux[ST_DPEND] = pend[1];
            rd_mux[ST_DAVL]  = avail[1];
            rd_mux[ST_IRQ]   = irq_active;
        end
    end

    assign host_rdata = rd_sel ? rd_mux : '0;

    // R2
    lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lane_wr[1], lane_wr[0]}));
    // R6
    data_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|lane_wr[1]) |=> !data_in_valid);
    // R10
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !msg_out_load && !data_out_load && !rd_sel) |=> host_req);
endmodule

// File: tb/tb_host_mailbox_port.sv
`timescale 1ns/100ps
module tb_host_mailbox_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 0, host_wr = 0, host_rd = 0;
    logic [3:0]  host_addr = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic        host_irq_n, host_req;
    logic        msg_in_valid, data_in_valid;
    logic [31:0] msg_in_word, data_in_word;
    logic        msg_in_ack = 0, msg_out_load = 0, data_in_ack = 0, data_out_load = 0;
    logic [31:0] msg_out_word = 0, data_out_word = 0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    host_mailbox_port dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq_n(host_irq_n), .host_req(host_req),
        .msg_in_valid(msg_in_valid), .msg_in_word(msg_in_word), .msg_in_ack(msg_in_ack),
        .msg_out_load(msg_out_load), .msg_out_word(msg_out_word),
        .data_in_valid(data_in_valid), .data_in_word(data_in_word), .data_in_ack(data_in_ack),
        .data_out_load(data_out_load), .data_out_word(data_out_word)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0]  m_stage [2][3];
    bit [31:0] m_out [2];
    bit [31:0] m_pword [2];
    bit        m_pulse [2];
    bit        m_pend [2];
    bit        m_avail [2];
    bit        m_irq;
    bit [3:0]  m_mask;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_out[c] = 0; m_pword[c] = 0; m_pulse[c] = 0; m_pend[c] = 0; m_avail[c] = 0;
                for (int k = 0; k < 3; k++) m_stage[c][k] = 0;
            end
            m_irq = 0; m_mask = 0;
        end else begin
            bit [3:0] ev;
            bit       ld [2];
            bit       ak [2];
            bit       wr, rd;
            wr = host_cs && host_wr;
            rd = host_cs && host_rd;
            ld[0] = msg_out_load;  ld[1] = data_out_load;
            ak[0] = msg_in_ack;    ak[1] = data_in_ack;
            ev = {ak[1] && m_pend[1], ld[1], ak[0] && m_pend[0], ld[0]};
            if ((ev & m_mask) != 0) m_irq = 1;
            else if (wr && host_addr == 8 && host_wdata[7]) m_irq = 0;
            for (int c = 0; c < 2; c++) begin
                m_pulse[c] = 0;
                if (wr && host_addr == 4*c + 3) begin
                    m_pword[c] = {m_stage[c][0], m_stage[c][1], m_stage[c][2], host_wdata};
                    m_pulse[c] = 1;
                    m_pend[c]  = 1;
                end else if (ak[c]) m_pend[c] = 0;
                for (int k = 0; k < 3; k++)
                    if (wr && host_addr == 4*c + k) m_stage[c][k] = host_wdata;
                if (ld[c]) begin
                    m_avail[c] = 1;
                    m_out[c] = (c == 0) ? msg_out_word : data_out_word;
                end else if (rd && host_addr == 4*c + 3) m_avail[c] = 0;
            end
            if (wr && host_addr == 8) m_mask = host_wdata[3:0];
        end
    end

    function automatic bit [7:0] exp_rd();
        if (!(host_cs && host_rd)) return 8'h00;
        if (host_addr < 8) return m_out[host_addr / 4][31 - 8*(host_addr % 4) -: 8];
        if (host_addr == 8) return {4'h0, m_mask};
        if (host_addr == 9) return {3'b0, m_irq, m_avail[1], m_pend[1], m_avail[0], m_pend[0]};
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison, 1 ns after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            chk("R2 rdata",        host_rdata, exp_rd());
            chk("R9 irq_n",        host_irq_n, !m_irq);
            chk("R10 req",         host_req, m_avail[0] || m_avail[1]);
            chk("R3 msg strobe",   msg_in_valid, m_pulse[0]);
            chk("R6 data strobe",  data_in_valid, m_pulse[1]);
            if (m_pulse[0]) chk("R3 msg word",  msg_in_word, m_pword[0]);
            if (m_pulse[1]) chk("R6 data word", data_in_word, m_pword[1]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_wr = 0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        host_cs = 1; host_rd = 1; host_addr = a;
        #0.5;
        d = host_rdata;
        @(negedge clk);
        host_cs = 0; host_rd = 0;
    endtask

    task automatic core_load(input int c, input logic [31:0] w);
        if (c == 0) begin msg_out_load = 1; msg_out_word = w; end
        else        begin data_out_load = 1; data_out_word = w; end
        @(negedge clk);
        msg_out_load = 0; data_out_load = 0;
    endtask

    task automatic core_ack(input int c);
        if (c == 0) msg_in_ack = 1; else data_in_ack = 1;
        @(negedge clk);
        msg_in_ack = 0; data_in_ack = 0;
    endtask

    // Watchdog.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        hread(4'd9, r); chk("R1 status", r, 8'h00);
        hread(4'd8, r); chk("R1 control", r, 8'h00);
        chk("R1 irq_n", host_irq_n, 1'b1);
        chk("R1 req", host_req, 1'b0);
        chk("R1 strobe", msg_in_valid | data_in_valid, 1'b0);

        // R3 commit on last byte
        hwrite(4'd0, 8'h11); hwrite(4'd1, 8'h22); hwrite(4'd2, 8'h33);
        chk("R4 no strobe on A-C", msg_in_valid, 1'b0);
        hwrite(4'd3, 8'h44);
        chk("R3 strobe", msg_in_valid, 1'b1);
        chk("R3 word", msg_in_word, 32'h11223344);
        @(negedge clk);
        chk("R3 single cycle", msg_in_valid, 1'b0);
        hwrite(4'd1, 8'h99);
        chk("R4 stage only", msg_in_valid, 1'b0);
        hread(4'd9, r); chk("R7 msg pending", r, 8'h01);
        core_ack(0);
        hread(4'd9, r); chk("R12 pend cleared", r, 8'h00);
        chk("R12 no irq when masked", host_irq_n, 1'b1);

        // R8 control and R9 interrupt
        hwrite(4'd8, 8'h8F);
        hread(4'd8, r); chk("R8 mask readback", r, 8'h0F);
        core_load(0, 32'hA1B2C3D4);
        chk("R9 irq on load", host_irq_n, 1'b0);
        chk("R10 req set", host_req, 1'b1);
        hread(4'd0, r); chk("R2 byte A", r, 8'hA1);
        hread(4'd1, r); chk("R2 byte B", r, 8'hB2);
        hread(4'd2, r); chk("R2 byte C", r, 8'hC3);
        hread(4'd3, r); chk("R2 byte D", r, 8'hD4);
        chk("R5 avail cleared", host_req, 1'b0);
        hread(4'd9, r); chk("R7 irq bit", r, 8'h10);
        chk("R9 irq held", host_irq_n, 1'b0);
        hwrite(4'd8, 8'h8F);
        chk("R9 ack releases", host_irq_n, 1'b1);

        // R6 data conduit isolation
        hwrite(4'd4, 8'hDE); hwrite(4'd5, 8'hAD); hwrite(4'd6, 8'hBE);
        hwrite(4'd7, 8'hEF);
        chk("R6 data strobe", data_in_valid, 1'b1);
        chk("R6 data word", data_in_word, 32'hDEADBEEF);
        chk("R6 msg quiet", msg_in_valid, 1'b0);
        hread(4'd9, r); chk("R7 data pending", r, 8'h04);
        core_ack(1);
        chk("R12 done event irq", host_irq_n, 1'b0);
        hwrite(4'd8, 8'h80);
        hread(4'd8, r); chk("R8 mask cleared", r, 8'h00);

        // R11 unimplemented addresses
        for (int a = 10; a < 16; a++) hwrite(4'(a), 8'hFF);
        for (int a = 10; a < 16; a++) begin
            hread(4'(a), r); chk("R11 zero read", r, 8'h00);
        end
        hread(4'd9, r); chk("R11 status untouched", r, 8'h00);
        hread(4'd8, r); chk("R11 control untouched", r, 8'h00);
        chk("R11 outputs", {host_irq_n, host_req, msg_in_valid, data_in_valid}, 4'b1000);

        // R5 load beats simultaneous last-byte read; masked load keeps irq off
        core_load(1, 32'h01020304);
        chk("R9 masked event", host_irq_n, 1'b1);
        host_cs = 1; host_rd = 1; host_addr = 4'd7;
        data_out_load = 1; data_out_word = 32'h55667788;
        @(negedge clk);
        host_cs = 0; host_rd = 0; data_out_load = 0;
        hread(4'd9, r); chk("R5 load wins", r, 8'h08);
        hread(4'd4, r); chk("R5 new word", r, 8'h55);
        hread(4'd7, r); chk("R5 D byte", r, 8'h88);
        chk("R10 req clears", host_req, 1'b0);

        // R9 event coinciding with acknowledge keeps irq asserted
        hwrite(4'd8, 8'h01);
        host_cs = 1; host_wr = 1; host_addr = 4'd8; host_wdata = 8'h81;
        msg_out_load = 1; msg_out_word = 32'hCAFEF00D;
        @(negedge clk);
        host_cs = 0; host_wr = 0; msg_out_load = 0;
        chk("R9 event beats ack", host_irq_n, 1'b0);
        hwrite(4'd8, 8'h80);
        chk("R9 later ack", host_irq_n, 1'b1);
        core_ack(0);
        chk("R12 idle ack no event", host_irq_n, 1'b1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule